// File: doc/BRIEF.md
# PRBS Bit Error Rate Tester

This block measures bit errors on a time-division multiplexed switch path. It inserts a pseudo-random sequence of period 2^15-1 into outgoing timeslots. It then watches one incoming timeslot, chosen by stream and channel number, for the same sequence and counts every bit that differs.

The transmit side sees a strobe for each outgoing timeslot, along with that channel's 2-bit mode field. When the mode selects the test pattern, the generator returns the next pattern byte. The receive side sees every incoming channel byte, tagged with its stream and channel.

The checker locks onto the incoming sequence by itself, so it does not need to know the sender's phase. Two control levels, `start_bit` and `clear_bit`, act only on their transitions:

- The rising edge of `start_bit` arms the test.
- The falling edge of `start_bit` stops the test and publishes the count.
- The rising edge of `clear_bit` wipes both the internal counter and the published result.

Top module: `prbs_ber_tester`

## Requirements
- R1: After reset, `err_count` is 0, `tx_pat_vld` is 0 and `tx_data` is 0.
- R2: The generator's bit sequence follows the rule: each new bit equals the XOR of the oldest and the second-oldest of the previous 15 bits (polynomial x^15+x^14+1). It starts from the register state `SEED`, with the newest bit in the LSB. A `tx_strobe` with `tx_mode` = 2'b11 outputs the next 8 bits on `tx_data` in the following cycle, first bit in bit 7, with `tx_pat_vld` high.
- R3: A `tx_strobe` with any other `tx_mode` gives `tx_pat_vld` = 0 and `tx_data` = 0 in the next cycle, and does not advance the sequence.
- R4: Only a byte with `rx_valid` high, `rx_stream` = `sel_stream` and `rx_chan` = `sel_chan`, arriving while a test is running, affects the count.
- R5: After each start edge, the first two selected bytes are not compared. Their last 15 bits become the checker's reference.
- R6: Each later selected byte is compared with the next 8 predicted bits. The number of differing bits is added to the internal counter.
- R7: A received byte of 8'hFF adds nothing to the count, and the prediction still moves on by 8 bits.
- R8: A rising edge of `start_bit` enables counting without clearing the internal counter. While stopped, the counter holds.
- R9: A falling edge of `start_bit` stops counting and copies the internal counter to `err_count`. At no other time except a clear does `err_count` change.
- R10: A rising edge of `clear_bit` zeroes both the internal counter and `err_count`, taking priority over any update in the same cycle.
- R11: The internal counter saturates at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_bit | input | 1 | Test run level; rising edge starts, falling edge stops |
| clear_bit | input | 1 | Rising edge clears counter and result |
| sel_stream | input | STRM_W | Stream number of the monitored input timeslot |
| sel_chan | input | CHAN_W | Channel number of the monitored input timeslot |
| tx_strobe | input | 1 | An outgoing timeslot is due |
| tx_mode | input | 2 | Mode field of that outgoing channel; 2'b11 selects the pattern |
| tx_pat_vld | output | 1 | `tx_data` holds a pattern byte |
| tx_data | output | 8 | Pattern byte for the outgoing timeslot |
| rx_valid | input | 1 | An incoming channel byte is present |
| rx_stream | input | STRM_W | Stream tag of the incoming byte |
| rx_chan | input | CHAN_W | Channel tag of the incoming byte |
| rx_data | input | 8 | Incoming channel byte |
| err_count | output | CNT_W | Published error count |

## Verification
The bench builds the block with its default parameters: 5-bit stream tags, 8-bit channel tags, a 16-bit counter and a nonzero seed. With the 16-bit counter, saturation can be reached by feeding a little over eight thousand heavily corrupted bytes, one per cycle. The separate stream and channel tag widths let the bench send bytes that match on one field but not the other, and confirm that such bytes have no effect on the count.

// File: rtl/prbs_ber_pkg.sv
package prbs_ber_pkg;

    localparam int PRBS_W = 15;
    localparam int OCT_W  = 8;

    typedef logic [PRBS_W-1:0] lfsr_t;
    typedef logic [OCT_W-1:0]  octet_t;

    localparam logic [1:0] MODE_PATTERN = 2'b11;

    typedef struct packed {
        lfsr_t  st;
        octet_t octet;
    } step_t;

    typedef enum logic [1:0] {
        SYNC_EMPTY,
        SYNC_HALF,
        SYNC_LOCKED
    } sync_e;

    // Advance the sequence by one octet; the first bit produced lands in bit 7.
    function automatic step_t prbs_step8(input lfsr_t s);
        step_t r;
        lfsr_t t;
        logic  b;
        t = s;
        r.octet = '0;
        for (int i = 0; i < OCT_W; i++) begin
            b = t[PRBS_W-1] ^ t[PRBS_W-2];
            t = {t[PRBS_W-2:0], b};
            r.octet[OCT_W-1-i] = b;
        end
        r.st = t;
        return r;
    endfunction

    function automatic logic [3:0] popcnt8(input octet_t v);
        logic [3:0] c;
        c = '0;
        for (int i = 0; i < OCT_W; i++) c = c + 4'(v[i]);
        return c;
    endfunction

endpackage

// File: rtl/prbs_gen.sv
module prbs_gen
    import prbs_ber_pkg::*;
#(
    parameter lfsr_t SEED = 15'h1D3B
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe,
    input  logic [1:0] mode,
    output logic       pat_vld,
    output octet_t     data
);
    lfsr_t st_q;
    step_t step;
    logic  fire;

    assign step = prbs_step8(st_q);
    assign fire = strobe && (mode == MODE_PATTERN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SEED;
            pat_vld <= 1'b0;
            data    <= '0;
        end else begin
            pat_vld <= fire;
            data    <= fire ? step.octet : '0;
            if (fire) st_q <= step.st;
        end
    end
endmodule

// File: rtl/prbs_chk.sv
module prbs_chk
    import prbs_ber_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       enable,
    input  logic       in_vld,
    input  octet_t     in_byte,
    output logic       err_vld,
    output logic [3:0] err_bits
);
    sync_e  phase_q;
    octet_t hold_q;
    lfsr_t  ref_q;
    step_t  pred;

    assign pred = prbs_step8(ref_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= SYNC_EMPTY;
            hold_q   <= '0;
            ref_q    <= '0;
            err_vld  <= 1'b0;
            err_bits <= '0;
        end else begin
            err_vld  <= 1'b0;
            err_bits <= '0;
            if (restart) begin
                phase_q <= SYNC_EMPTY;
            end else if (enable && in_vld) begin
                unique case (phase_q)
                    SYNC_EMPTY: begin
                        hold_q  <= in_byte;
                        phase_q <= SYNC_HALF;
                    end
                    SYNC_HALF: begin
                        ref_q   <= {hold_q[PRBS_W-OCT_W-1:0], in_byte};
                        phase_q <= SYNC_LOCKED;
                    end
                    default: begin
                        ref_q    <= pred.st;
                        err_vld  <= 1'b1;
                        err_bits <= (in_byte == 8'hFF) ? 4'd0
                                                       : popcnt8(in_byte ^ pred.octet);
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/err_tally.sv
module err_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_lvl,
    input  logic             clear_lvl,
    input  logic             err_vld,
    input  logic [3:0]       err_bits,
    output logic             start_rise,
    output logic             running,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] result
);
    logic             start_q, clear_q;
    logic             start_fall, clear_rise;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] cnt_nxt;

    assign start_rise = start_lvl & ~start_q;
    assign start_fall = ~start_lvl & start_q;
    assign clear_rise = clear_lvl & ~clear_q;

    assign sum     = {1'b0, cnt} + {{(CNT_W-3){1'b0}}, err_bits};
    assign cnt_nxt = sum[CNT_W] ? '1 : sum[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            clear_q <= 1'b0;
            running <= 1'b0;
            cnt     <= '0;
            result  <= '0;
        end else begin
            start_q <= start_lvl;
            clear_q <= clear_lvl;
            if (start_rise)      running <= 1'b1;
            else if (start_fall) running <= 1'b0;
            if (clear_rise) begin
                cnt    <= '0;
                result <= '0;
            end else begin
                if (start_fall)         result <= cnt;
                if (running && err_vld) cnt    <= cnt_nxt;
            end
        end
    end
endmodule

// File: rtl/prbs_ber_tester.sv
module prbs_ber_tester
    import prbs_ber_pkg::*;
#(
    parameter int    STRM_W = 5,
    parameter int    CHAN_W = 8,
    parameter int    CNT_W  = 16,
    parameter lfsr_t SEED   = 15'h1D3B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_bit,
    input  logic              clear_bit,
    input  logic [STRM_W-1:0] sel_stream,
    input  logic [CHAN_W-1:0] sel_chan,
    input  logic              tx_strobe,
    input  logic [1:0]        tx_mode,
    output logic              tx_pat_vld,
    output logic [7:0]        tx_data,
    input  logic              rx_valid,
    input  logic [STRM_W-1:0] rx_stream,
    input  logic [CHAN_W-1:0] rx_chan,
    input  logic [7:0]        rx_data,
    output logic [CNT_W-1:0]  err_count
);
    logic             rx_hit;
    logic             start_rise;
    logic             running;
    logic             err_vld;
    logic [3:0]       err_bits;
    logic [CNT_W-1:0] tally_cnt;

    assign rx_hit = rx_valid && (rx_stream == sel_stream) && (rx_chan == sel_chan);

    prbs_gen #(.SEED(SEED)) u_gen (
        .clk     (clk),
        .rst     (rst),
        .strobe  (tx_strobe),
        .mode    (tx_mode),
        .pat_vld (tx_pat_vld),
        .data    (tx_data)
    );

    prbs_chk u_chk (
        .clk      (clk),
        .rst      (rst),
        .restart  (start_rise),
        .enable   (running),
        .in_vld   (rx_hit),
        .in_byte  (rx_data),
        .err_vld  (err_vld),
        .err_bits (err_bits)
    );

    err_tally #(.CNT_W(CNT_W)) u_tally (
        .clk        (clk),
        .rst        (rst),
        .start_lvl  (start_bit),
        .clear_lvl  (clear_bit),
        .err_vld    (err_vld),
        .err_bits   (err_bits),
        .start_rise (start_rise),
        .running    (running),
        .cnt        (tally_cnt),
        .result     (err_count)
    );
endmodule

// File: rtl/prbs_ber_sva.sv
module prbs_ber_sva #(
    parameter int STRM_W = 5,
    parameter int CHAN_W = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start_bit,
    input logic              clear_bit,
    input logic [STRM_W-1:0] sel_stream,
    input logic [CHAN_W-1:0] sel_chan,
    input logic              tx_strobe,
    input logic [1:0]        tx_mode,
    input logic              tx_pat_vld,
    input logic              rx_valid,
    input logic [STRM_W-1:0] rx_stream,
    input logic [CHAN_W-1:0] rx_chan,
    input logic [7:0]        rx_data,
    input logic [CNT_W-1:0]  err_count,
    input logic              running,
    input logic [CNT_W-1:0]  tally_cnt,
    input logic              err_vld,
    input logic [3:0]        err_bits
);
    AST_PAT_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        tx_pat_vld |-> $past(tx_strobe && tx_mode == 2'b11)); // R2

    AST_OTHER_MODE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (tx_strobe && tx_mode != 2'b11) |=> !tx_pat_vld); // R3

    AST_ONES_FREE: assert property (@(posedge clk) disable iff (rst)
        $past(rx_valid && rx_stream == sel_stream && rx_chan == sel_chan && rx_data == 8'hFF)
        |-> !(err_vld && err_bits != 4'd0)); // R7

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!running && !$rose(clear_bit)) |=> $stable(tally_cnt)); // R8

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$rose(clear_bit) && !$fell(start_bit)) |=> $stable(err_count)); // R9

    AST_STOP_COPY: assert property (@(posedge clk) disable iff (rst)
        ($fell(start_bit) && !$rose(clear_bit)) |=> err_count == $past(tally_cnt)); // R9

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(clear_bit) |=> (err_count == '0 && tally_cnt == '0)); // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (&tally_cnt && !$rose(clear_bit)) |=> &tally_cnt); // R11
endmodule

bind prbs_ber_tester prbs_ber_sva #(
    .STRM_W (STRM_W),
    .CHAN_W (CHAN_W),
    .CNT_W  (CNT_W)
) u_sva (
    .clk        (clk),
    .rst        (rst),
    .start_bit  (start_bit),
    .clear_bit  (clear_bit),
    .sel_stream (sel_stream),
    .sel_chan   (sel_chan),
    .tx_strobe  (tx_strobe),
    .tx_mode    (tx_mode),
    .tx_pat_vld (tx_pat_vld),
    .rx_valid   (rx_valid),
    .rx_stream  (rx_stream),
    .rx_chan    (rx_chan),
    .rx_data    (rx_data),
    .err_count  (err_count),
    .running    (running),
    .tally_cnt  (tally_cnt),
    .err_vld    (err_vld),
    .err_bits   (err_bits)
);

// File: tb/sim_prbs_ber_tester.sv
module sim_prbs_ber_tester;
    localparam int          STRM_W = 5;
    localparam int          CHAN_W = 8;
    localparam int          CNT_W  = 16;
    localparam logic [14:0] SEED   = 15'h1D3B;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_bit = 1'b0, clear_bit = 1'b0;
    logic [STRM_W-1:0] sel_stream = 5'd19;
    logic [CHAN_W-1:0] sel_chan   = 8'd77;
    logic              tx_strobe = 1'b0;
    logic [1:0]        tx_mode = 2'b00;
    logic              tx_pat_vld;
    logic [7:0]        tx_data;
    logic              rx_valid = 1'b0;
    logic [STRM_W-1:0] rx_stream = '0;
    logic [CHAN_W-1:0] rx_chan = '0;
    logic [7:0]        rx_data = '0;
    logic [CNT_W-1:0]  err_count;

    int          n_chk = 0, n_fail = 0;
    logic [14:0] gm, rm;
    longint      exp_cnt = 0;

    always #2 clk = ~clk;

    prbs_ber_tester #(.STRM_W(STRM_W), .CHAN_W(CHAN_W), .CNT_W(CNT_W), .SEED(SEED)) u0 (
        .clk(clk), .rst(rst), .start_bit(start_bit), .clear_bit(clear_bit),
        .sel_stream(sel_stream), .sel_chan(sel_chan),
        .tx_strobe(tx_strobe), .tx_mode(tx_mode), .tx_pat_vld(tx_pat_vld), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_stream(rx_stream), .rx_chan(rx_chan), .rx_data(rx_data),
        .err_count(err_count)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference sequence model: new bit = bit14 ^ bit13, newest bit enters at bit 0.
    task automatic model8(inout logic [14:0] s, output logic [7:0] o);
        for (int i = 7; i >= 0; i--) begin
            o[i] = s[14] ^ s[13];
            s = {s[13:0], o[i]};
        end
    endtask

    task automatic put_rx(input logic [STRM_W-1:0] s, input logic [CHAN_W-1:0] c,
                          input logic [7:0] d, input logic v);
        @(negedge clk);
        rx_valid = v; rx_stream = s; rx_chan = c; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic begin_run(input logic [14:0] phase);
        logic [7:0] o;
        @(negedge clk); start_bit = 1'b1;
        @(negedge clk);
        rm = phase;
        for (int i = 0; i < 2; i++) begin
            model8(rm, o);
            put_rx(sel_stream, sel_chan, o, 1'b1);
        end
    endtask

    task automatic send_masked(input logic [7:0] mask);
        logic [7:0] p, d;
        model8(rm, p);
        d = p ^ mask;
        if (d != 8'hFF) exp_cnt += $countones(p ^ d);
        if (exp_cnt > 65535) exp_cnt = 65535;
        put_rx(sel_stream, sel_chan, d, 1'b1);
    endtask

    task automatic end_run(input string req);
        repeat (3) @(negedge clk);
        start_bit = 1'b0;
        @(negedge clk);
        check(req, err_count, exp_cnt);
    endtask

    task automatic t_reset;
        check("R1 count", err_count, 0);
        check("R1 pat_vld", tx_pat_vld, 0);
        check("R1 data", tx_data, 0);
    endtask

    task automatic t_tx;
        logic [7:0] o;
        gm = SEED;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); tx_strobe = 1'b1; tx_mode = 2'b11;
            @(negedge clk); tx_strobe = 1'b0;
            model8(gm, o);
            check("R2 pattern byte", tx_data, o);
            check("R2 pat_vld", tx_pat_vld, 1);
        end
        @(negedge clk); tx_strobe = 1'b1; tx_mode = 2'b01;
        @(negedge clk); tx_strobe = 1'b0;
        check("R3 pat_vld low", tx_pat_vld, 0);
        check("R3 data zero", tx_data, 0);
        @(negedge clk); tx_strobe = 1'b1; tx_mode = 2'b11;
        @(negedge clk); tx_strobe = 1'b0;
        model8(gm, o);
        check("R3 no advance", tx_data, o);
    endtask

    task automatic t_clean;
        begin_run(15'h2C11);
        for (int i = 0; i < 6; i++) begin
            send_masked(8'h00);
            put_rx(sel_stream, sel_chan + 8'd1, 8'h5A, 1'b1);   // R4 wrong channel
            put_rx(sel_stream ^ 5'd1, sel_chan, 8'h33, 1'b1);   // R4 wrong stream
            put_rx(sel_stream, sel_chan, 8'h0F, 1'b0);          // R4 not valid
        end
        end_run("R4 R5 R6 clean run");
    endtask

    task automatic t_errors;
        begin_run(15'h0F0F);
        send_masked(8'h01);
        send_masked(8'h81);
        send_masked(8'hF0);
        send_masked(8'h3C);
        end_run("R6 R8 accumulated errors");
    endtask

    task automatic t_ones;
        logic [7:0] p;
        begin_run(15'h6001);
        model8(rm, p);
        put_rx(sel_stream, sel_chan, 8'hFF, 1'b1);
        send_masked(8'h00);
        send_masked(8'h10);
        end_run("R7 all ones ignored");
    endtask

    task automatic t_idle;
        for (int i = 0; i < 4; i++) put_rx(sel_stream, sel_chan, 8'hA5, 1'b1);
        check("R9 result held while stopped", err_count, exp_cnt);
        @(negedge clk); start_bit = 1'b1;
        repeat (2) @(negedge clk);
        end_run("R8 counter held while stopped");
    endtask

    task automatic t_clear;
        @(negedge clk); clear_bit = 1'b1;
        @(negedge clk);
        exp_cnt = 0;
        check("R10 result cleared", err_count, 0);
        clear_bit = 1'b0;
        @(negedge clk); start_bit = 1'b1;
        repeat (2) @(negedge clk);
        end_run("R10 internal counter cleared");
    endtask

    task automatic t_sat;
        logic [7:0] p;
        begin_run(15'h1234);
        for (int i = 0; i < 8400; i++) begin
            logic [14:0] peek;
            peek = rm;
            model8(peek, p);
            send_masked(p == 8'h00 ? 8'h7F : 8'hFF);
        end
        end_run("R11 saturation");
        check("R11 saturated value", err_count, 16'hFFFF);
        @(negedge clk); clear_bit = 1'b1;
        @(negedge clk); clear_bit = 1'b0;
        exp_cnt = 0;
        check("R10 clear after saturation", err_count, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_tx();
        t_clean();
        t_errors();
        t_ones();
        t_idle();
        t_clear();
        t_sat();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule